// File: doc/BRIEF.md
# Idle Power-Down Sequencer for a Dual-Clock FIFO

This block decides when the write side and the read side of a dual-clock FIFO core may act, based on one asynchronous, active-low power-down request. Each clock domain has its own copy of the sequencer. Each copy synchronizes the request into its own clock. While the domain is powered down, it blocks that domain's enables and chip selects, stops every clock-driven state update in the core, and turns off the output enables of the domain's data and echo outputs. Pointers, flags, offsets and counters inside the core keep their values because their update enable stays low.

Before the request arrives, the enables must have been idle for a minimum number of cycles. If that idle period is too short, the block raises an entry error and holds it for the whole powered-down period.

When the request is released, the domain does not return to normal operation at once. It first spends a settling period of a parameterised number of cycles, sized to match 1 µs. During that period the outputs are driven again but operations stay blocked. The domain then returns to normal operation and continues from the retained state without any reset.

Each domain steps through three named states:
- RUN: normal operation. The domain moves RUN→DOWN when the synchronized request is seen.
- DOWN: powered down. The domain moves DOWN→SETTLE when the synchronized request clears.
- SETTLE: timed wait. The domain moves SETTLE→RUN when the settling count completes, or SETTLE→DOWN if the request comes back before then.

Top module: `lp_idle_seq`

## Requirements
- R1: `pd_n` is asynchronous and active low. It passes through a two-stage synchronizer in each domain. The domain enters DOWN on the third rising edge of its clock after `pd_n` goes low, and is still in RUN after the second edge.
- R2: In DOWN and SETTLE, the gated enable and gated chip-select outputs of the domain are 0 whatever its inputs are, and the core update enable `*_upd_o` is 0.
- R3: The output enable `*_oe_o` is 0 in DOWN and 1 in RUN and SETTLE.
- R4: While the request stays asserted, clock edges in DOWN change none of the domain's outputs, and the entry error keeps its value.
- R5: The entry error `*_err_o` is set when DOWN is entered and the enable input of that domain has been 0 at fewer than 4 consecutive rising edges up to and including the edge before entry. It stays 0 otherwise. It is cleared on DOWN→SETTLE.
- R6: `*_ready_o` is 1 only in RUN. After `pd_n` rises, ready is still 0 after SETTLE_CYC+2 rising edges and becomes 1 after SETTLE_CYC+3 edges. The default SETTLE_CYC is 100, which is 1 µs at 100 MHz.
- R7: In RUN, the gated enable and chip select follow their inputs combinationally, and `*_upd_o` is 1. After a power-down cycle this holds again without any reset.
- R8: If the request returns during SETTLE, the domain goes back to DOWN, and the settling count restarts from zero on the next exit.
- R9: After reset, both domains are in RUN with ready 1, output enables 1 and entry errors 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| wr_en_i | input | 1 | Write enable from the user |
| wr_cs_i | input | 1 | Write chip select from the user |
| rd_en_i | input | 1 | Read enable from the user |
| rd_cs_i | input | 1 | Read chip select from the user |
| wr_en_o | output | 1 | Gated write enable to the core |
| wr_cs_o | output | 1 | Gated write chip select to the core |
| wr_upd_o | output | 1 | Write-domain core state update enable |
| wr_oe_o | output | 1 | Output enable for write-side echo outputs |
| wr_ready_o | output | 1 | Write domain operational |
| wr_err_o | output | 1 | Write-domain entry precondition violation |
| rd_en_o | output | 1 | Gated read enable to the core |
| rd_cs_o | output | 1 | Gated read chip select to the core |
| rd_upd_o | output | 1 | Read-domain core state update enable |
| rd_oe_o | output | 1 | Output enable for read data and echo outputs |
| rd_ready_o | output | 1 | Read domain operational |
| rd_err_o | output | 1 | Read-domain entry precondition violation |

## Verification
The hardest case to reach is SETTLE→DOWN. It needs a release that the synchronizer actually sees, followed by a new request a few cycles later, before the 100-cycle settling count ends. A directed sequence releases `pd_n`, waits until the domain has clearly entered SETTLE, asserts `pd_n` again, and then checks that the next exit takes the full settling time. The boundary of the idle rule is also hard to hit by chance. The idle length before entry is therefore drawn at random, and the cases of 1 and 2 idle cycles before the request are also driven on purpose, because these two values sit on either side of the four-edge threshold once the synchronizer latency is counted.

// File: rtl/lp_idle_seq_pkg.sv
package lp_idle_seq_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_DOWN   = 2'd1,
        PS_SETTLE = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/lp_pd_sync.sv
module lp_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic pd_req
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= ~pd_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign pd_req = chain_q[STAGES-1];

    // R1: the synchronized request only takes a value the previous stage held
    assert_sync_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_q[STAGES-1] != $past(chain_q[STAGES-1])) |-> $past(chain_q[STAGES-1]) != $past(chain_q[STAGES-2]))
        else $error("sync stage jumped");
endmodule

// File: rtl/lp_pd_domain.sv
module lp_pd_domain
    import lp_idle_seq_pkg::*;
#(
    parameter int IDLE_CYC   = 4,
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic en_i,
    input  logic cs_i,
    output logic en_o,
    output logic cs_o,
    output logic upd_o,
    output logic oe_o,
    output logic ready_o,
    output logic err_o
);
    localparam int IDLE_W   = $clog2(IDLE_CYC + 1);
    localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
    localparam logic [IDLE_W-1:0]   IDLE_MAX    = IDLE_W'(IDLE_CYC);
    localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_CYC - 1);

    pwr_state_e           state_q, state_d;
    logic [IDLE_W-1:0]    idle_cnt_q;
    logic [SETTLE_W-1:0]  settle_cnt_q;
    logic                 err_q;
    logic                 idle_ok;
    logic                 settle_done;

    assign idle_ok     = (idle_cnt_q >= IDLE_MAX);
    assign settle_done = (settle_cnt_q == SETTLE_LAST);

    // consecutive idle edges of the raw enable, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idle_cnt_q <= '0;
        else if (en_i)               idle_cnt_q <= '0;
        else if (idle_cnt_q != IDLE_MAX) idle_cnt_q <= idle_cnt_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:    if (pd_req)      state_d = PS_DOWN;
            PS_DOWN:   if (!pd_req)     state_d = PS_SETTLE;
            PS_SETTLE: if (pd_req)      state_d = PS_DOWN;
                       else if (settle_done) state_d = PS_RUN;
            default:                    state_d = PS_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // settling counter, only advances in SETTLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   settle_cnt_q <= '0;
        else if (state_q == PS_SETTLE && state_d == PS_SETTLE) settle_cnt_q <= settle_cnt_q + 1'b1;
        else                                          settle_cnt_q <= '0;
    end

    // entry error: captured on entry to DOWN, cleared on leaving DOWN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          err_q <= 1'b0;
        else if (state_q != PS_DOWN && state_d == PS_DOWN)   err_q <= ~idle_ok;
        else if (state_q == PS_DOWN && state_d == PS_SETTLE) err_q <= 1'b0;
    end

    // outputs
    always_comb begin
        en_o    = 1'b0;
        cs_o    = 1'b0;
        upd_o   = 1'b0;
        oe_o    = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            PS_RUN: begin
                en_o    = en_i;
                cs_o    = cs_i;
                upd_o   = 1'b1;
                oe_o    = 1'b1;
                ready_o = 1'b1;
            end
            PS_DOWN: begin
                oe_o = 1'b0;
            end
            PS_SETTLE: begin
                oe_o = 1'b1;
            end
            default: begin
                oe_o = 1'b0;
            end
        endcase
    end

    assign err_o = err_q;

    // R1: DOWN is only entered on a synchronized request
    assert_entry_on_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DOWN && $past(state_q) != PS_DOWN) |-> $past(pd_req))
        else $error("DOWN without request");

    // R4: a held request keeps DOWN and the error value
    assert_hold_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DOWN && pd_req) |=> (state_q == PS_DOWN && $stable(err_o)))
        else $error("DOWN state not retained");

    // R6: ready rises only after the full settling count
    assert_settle_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(settle_cnt_q) == SETTLE_LAST)
        else $error("ready rose early");

    // R6: release from DOWN goes through SETTLE
    assert_exit_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DOWN && !pd_req) |=> state_q == PS_SETTLE)
        else $error("exit skipped SETTLE");

    // R8: request during SETTLE returns to DOWN and restarts the count
    assert_reenter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SETTLE && pd_req) |=> (state_q == PS_DOWN && settle_cnt_q == '0))
        else $error("re-entry failed");
endmodule

// File: rtl/lp_idle_seq.sv
module lp_idle_seq #(
    parameter int SYNC_STAGES   = 2,
    parameter int IDLE_CYC      = 4,
    parameter int WR_SETTLE_CYC = 100,
    parameter int RD_SETTLE_CYC = 100
) (
    input  logic wclk,
    input  logic wrst_n,
    input  logic rclk,
    input  logic rrst_n,
    input  logic pd_n,
    input  logic wr_en_i,
    input  logic wr_cs_i,
    input  logic rd_en_i,
    input  logic rd_cs_i,
    output logic wr_en_o,
    output logic wr_cs_o,
    output logic wr_upd_o,
    output logic wr_oe_o,
    output logic wr_ready_o,
    output logic wr_err_o,
    output logic rd_en_o,
    output logic rd_cs_o,
    output logic rd_upd_o,
    output logic rd_oe_o,
    output logic rd_ready_o,
    output logic rd_err_o
);
    logic wr_pd_req;
    logic rd_pd_req;

    lp_pd_sync #(.STAGES(SYNC_STAGES)) wr_sync_i (
        .clk(wclk), .rst_n(wrst_n), .pd_n(pd_n), .pd_req(wr_pd_req));

    lp_pd_sync #(.STAGES(SYNC_STAGES)) rd_sync_i (
        .clk(rclk), .rst_n(rrst_n), .pd_n(pd_n), .pd_req(rd_pd_req));

    lp_pd_domain #(.IDLE_CYC(IDLE_CYC), .SETTLE_CYC(WR_SETTLE_CYC)) wr_dom_i (
        .clk(wclk), .rst_n(wrst_n), .pd_req(wr_pd_req),
        .en_i(wr_en_i), .cs_i(wr_cs_i),
        .en_o(wr_en_o), .cs_o(wr_cs_o), .upd_o(wr_upd_o),
        .oe_o(wr_oe_o), .ready_o(wr_ready_o), .err_o(wr_err_o));

    lp_pd_domain #(.IDLE_CYC(IDLE_CYC), .SETTLE_CYC(RD_SETTLE_CYC)) rd_dom_i (
        .clk(rclk), .rst_n(rrst_n), .pd_req(rd_pd_req),
        .en_i(rd_en_i), .cs_i(rd_cs_i),
        .en_o(rd_en_o), .cs_o(rd_cs_o), .upd_o(rd_upd_o),
        .oe_o(rd_oe_o), .ready_o(rd_ready_o), .err_o(rd_err_o));
endmodule

// File: tb/lp_idle_seq_tb_top.sv
`timescale 1ns/1ps
module lp_idle_seq_tb_top;
    localparam int SETTLE = 100;
    localparam int IDLE   = 4;
    localparam int SYNC   = 2;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wrst_n = 1'b0, rrst_n = 1'b0;
    logic pd_n = 1'b1;
    logic wr_en_i = 1'b0, wr_cs_i = 1'b0, rd_en_i = 1'b0, rd_cs_i = 1'b0;
    logic wr_en_o, wr_cs_o, wr_upd_o, wr_oe_o, wr_ready_o, wr_err_o;
    logic rd_en_o, rd_cs_o, rd_upd_o, rd_oe_o, rd_ready_o, rd_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 wclk = ~wclk;
    initial begin
        #2.5;
        forever #5 rclk = ~rclk;
    end

    lp_idle_seq dut_i (
        .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n), .pd_n(pd_n),
        .wr_en_i(wr_en_i), .wr_cs_i(wr_cs_i), .rd_en_i(rd_en_i), .rd_cs_i(rd_cs_i),
        .wr_en_o(wr_en_o), .wr_cs_o(wr_cs_o), .wr_upd_o(wr_upd_o), .wr_oe_o(wr_oe_o),
        .wr_ready_o(wr_ready_o), .wr_err_o(wr_err_o),
        .rd_en_o(rd_en_o), .rd_cs_o(rd_cs_o), .rd_upd_o(rd_upd_o), .rd_oe_o(rd_oe_o),
        .rd_ready_o(rd_ready_o), .rd_err_o(rd_err_o));

    function automatic bit exp_err(input int idle_edges);
        return (idle_edges + SYNC) < IDLE;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge wclk);
    endtask

    task automatic drive(input logic we, input logic wc, input logic re, input logic rc);
        wr_en_i = we; wr_cs_i = wc; rd_en_i = re; rd_cs_i = rc;
    endtask

    task automatic drive_rand();
        drive(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic check_run(input string req);
        #1;
        check(req, {wr_en_o, wr_cs_o, rd_en_o, rd_cs_o}, {wr_en_i, wr_cs_i, rd_en_i, rd_cs_i});
        check(req, {wr_upd_o, rd_upd_o, wr_ready_o, rd_ready_o, wr_oe_o, rd_oe_o}, 6'b111111);
    endtask

    task automatic check_down(input string req, input logic e);
        check(req, {wr_en_o, wr_cs_o, rd_en_o, rd_cs_o, wr_upd_o, rd_upd_o}, 6'b0);
        check(req, {wr_oe_o, rd_oe_o, wr_ready_o, rd_ready_o}, 4'b0);
        check(req, {wr_err_o, rd_err_o}, {e, e});
    endtask

    // power-down cycle with k idle edges before the request
    task automatic pd_cycle(input int k, input bit en_hot, input int dlen);
        logic e;
        e = en_hot ? 1'b1 : exp_err(k);
        drive(1, 1, 1, 1);
        step(1);
        if (!en_hot) drive(0, 0, 0, 0);
        step(k);
        pd_n = 1'b0;
        step(SYNC);
        check("R1", {wr_ready_o, rd_ready_o}, 2'b11);
        if (en_hot) drive(0, 0, 0, 0);
        step(1);
        check_down("R1", e);
        check("R5", {wr_err_o, rd_err_o}, {e, e});
        for (int i = 0; i < dlen; i++) begin
            drive_rand();
            step(1);
            check_down("R2", e);
            check("R4", {wr_err_o, rd_err_o}, {e, e});
            check("R3", {wr_oe_o, rd_oe_o}, 2'b00);
        end
        pd_n = 1'b1;
        step(SYNC + SETTLE);
        check("R6", {wr_ready_o, rd_ready_o}, 2'b00);
        check("R3", {wr_oe_o, rd_oe_o}, 2'b11);
        check("R2", {wr_en_o, rd_en_o, wr_upd_o, rd_upd_o}, 4'b0);
        check("R5", {wr_err_o, rd_err_o}, 2'b00);
        step(1);
        check("R6", {wr_ready_o, rd_ready_o}, 2'b11);
        drive_rand();
        check_run("R7");
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(3);
        wrst_n = 1'b1; rrst_n = 1'b1;
        step(1);
        check("R9", {wr_ready_o, rd_ready_o, wr_oe_o, rd_oe_o}, 4'b1111);
        check("R9", {wr_err_o, rd_err_o}, 2'b00);

        for (int i = 0; i < 10; i++) begin
            drive_rand();
            check_run("R7");
            step(1);
        end

        // directed idle-boundary cases
        pd_cycle(1, 1'b0, 6);   // 1 + 2 sync edges = 3 idle: error
        pd_cycle(2, 1'b0, 6);   // exactly 4 idle: no error
        pd_cycle(0, 1'b1, 5);   // enables active until entry: error
        pd_cycle(8, 1'b0, 4);

        // random cycles
        for (int i = 0; i < 12; i++) begin
            pd_cycle($urandom_range(0, 6), 1'b0, $urandom_range(3, 20));
        end

        // R8: re-request during SETTLE
        drive(0, 0, 0, 0);
        step(8);
        pd_n = 1'b0;
        step(SYNC + 1);
        check_down("R8", 1'b0);
        pd_n = 1'b1;
        step(SYNC + 1 + 5);
        check("R8", {wr_ready_o, rd_ready_o, wr_oe_o, rd_oe_o}, 4'b0011);
        pd_n = 1'b0;
        step(SYNC + 1);
        check_down("R8", 1'b0);
        pd_n = 1'b1;
        step(SYNC + SETTLE);
        check("R8", {wr_ready_o, rd_ready_o}, 2'b00);
        step(1);
        check("R8", {wr_ready_o, rd_ready_o}, 2'b11);
        drive_rand();
        check_run("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule